// File: doc/BRIEF.md
# Descriptor Ring Cache Controller

This block keeps a small on-chip cache of descriptors that live in a circular ring in host memory. Four values describe the ring: a base address, a length in descriptors, a head index and a tail index. Software moves the tail. The block moves the head. A cache pointer records where the next fetch starts. When the ring holds entries that are not yet cached, the block works out a burst size. It then issues one DMA read request carrying a byte address and a descriptor count. When the read completes, the new entries join the cache as unused.

The packet engine claims cached descriptors one at a time with a consume strobe, and each claimed descriptor becomes used. A writeback start strobe asks the block to return used descriptors to memory with a DMA write request. When that write completes, the block retires the entries and advances the head. If used entries remain, it tries again by itself. Neither kind of burst ever crosses the end of the ring. Writebacks can also be trimmed to an alignment mask.

If software changes the ring geometry while the cache holds entries or a transfer is in flight, a sticky error flag is raised.

Top module: `desc_ring_cache`

## Requirements
- R1: A synchronous reset empties both cache counts, clears the head, the cache pointer and the error flag, and leaves both request outputs low.
- R2: The fetch count before any cap is tail minus cache pointer when tail is greater than or equal to the cache pointer, and ring length minus cache pointer otherwise. A ring length of zero gives a count of zero.
- R3: The fetch count is capped at the free slots, which are DEPTH minus used minus unused. When no slot is free, no read is requested.
- R4: A read is requested only when no earlier fetch is outstanding and the count is nonzero. Its address is base plus cache pointer times DESC_BYTES.
- R5: When a fetch completes, the unused count grows by the fetched count and the cache pointer advances by it. The pointer becomes zero exactly when the sum equals the ring length.
- R6: Each consume strobe moves one entry from unused to used. A consume with no unused entry changes neither count.
- R7: A writeback starts on the start strobe when none is outstanding. Its count is the used count, limited to ring length minus head so that the burst ends at or before the ring end. Its address is base plus head times DESC_BYTES.
- R8: When the burst is not cut at the ring end and the alignment mask is nonzero, the count is the used count with the mask bits cleared. A zero count issues no write.
- R9: When a writeback completes, the used count drops by its count and the head advances modulo the ring length. If used entries remain, another writeback is attempted without a new start strobe.
- R10: A head load strobe sets both the head and the cache pointer to the loaded value.
- R11: The error flag is set, and stays set until reset, when base or length changes, or the head is loaded, while entries are cached or a transfer is in flight. A head load on an idle, empty cache does not set it.
- R12: A pending read or write request keeps its valid, address and count unchanged until the ready input accepts it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| ring_base | input | ADDR_W | Byte address of ring entry zero |
| ring_len | input | IDX_W | Ring length in descriptors |
| ring_tail | input | IDX_W | Tail index written by software |
| head_wr | input | 1 | Head load strobe |
| head_wr_val | input | IDX_W | Value for head load |
| wb_align | input | CNT_W | Writeback alignment mask |
| wb_start | input | 1 | Writeback start strobe |
| consume | input | 1 | Packet engine claims one unused entry |
| rd_valid | output | 1 | DMA read request valid |
| rd_ready | input | 1 | DMA read request accepted |
| rd_addr | output | ADDR_W | DMA read byte address |
| rd_cnt | output | CNT_W | Descriptors to read |
| rd_done | input | 1 | DMA read completion pulse |
| wr_valid | output | 1 | DMA write request valid |
| wr_ready | input | 1 | DMA write request accepted |
| wr_addr | output | ADDR_W | DMA write byte address |
| wr_cnt | output | CNT_W | Descriptors to write back |
| wr_done | input | 1 | DMA write completion pulse |
| ring_head | output | IDX_W | Current head index |
| cache_ptr | output | IDX_W | Next ring index to fetch |
| unused_cnt | output | CNT_W | Cached entries not yet consumed |
| used_cnt | output | CNT_W | Consumed entries awaiting writeback |
| cfg_err | output | 1 | Sticky configuration error |

## Verification
The bench builds the block with a four-entry cache, a 4-bit ring index, 16-byte descriptors and 16-bit addresses. The tiny cache lets a fetch hit the free-slot cap, or find no free slot at all, after just two bursts. Rings of ten and twelve entries let both fetch and writeback reach the ring end and wrap the head and cache pointer within a few transfers. Because the descriptor size is a power of two, the bench exercises the shift form of the address generator.

// File: rtl/drc_pkg.sv
package drc_pkg;

   function automatic bit is_pow2(input int v);
      return (v > 0) && ((v & (v - 1)) == 0);
   endfunction

   function automatic int max2(input int a, input int b);
      return (a > b) ? a : b;
   endfunction

endpackage

// File: rtl/drc_addr_gen.sv
module drc_addr_gen
   import drc_pkg::*;
#(
   parameter int ADDR_W     = 32,
   parameter int IDX_W      = 12,
   parameter int DESC_BYTES = 16
) (
   input  logic [ADDR_W-1:0] base,
   input  logic [IDX_W-1:0]  idx,
   output logic [ADDR_W-1:0] addr
);

   generate
      if (is_pow2(DESC_BYTES)) begin : g_shift
         localparam int SH = $clog2(DESC_BYTES);
         assign addr = base + (ADDR_W'(idx) << SH);
      end else begin : g_mul
         assign addr = base + ADDR_W'(idx) * ADDR_W'(DESC_BYTES);
      end
   endgenerate

endmodule

// File: rtl/drc_fetch.sv
module drc_fetch
   import drc_pkg::*;
#(
   parameter int ADDR_W     = 32,
   parameter int IDX_W      = 12,
   parameter int DEPTH      = 16,
   parameter int DESC_BYTES = 16,
   parameter int CNT_W      = 5
) (
   input  logic              clk,
   input  logic              rst,
   input  logic [ADDR_W-1:0] base,
   input  logic [IDX_W-1:0]  len,
   input  logic [IDX_W-1:0]  tail,
   input  logic [CNT_W-1:0]  used,
   input  logic [CNT_W-1:0]  unused,
   input  logic              ld,
   input  logic [IDX_W-1:0]  ld_val,
   output logic              req_valid,
   input  logic              req_ready,
   output logic [ADDR_W-1:0] req_addr,
   output logic [CNT_W-1:0]  req_cnt,
   input  logic              done,
   output logic [IDX_W-1:0]  cptr,
   output logic              fill_en,
   output logic              busy
);

   localparam int MW  = max2(IDX_W, CNT_W);
   localparam int IW1 = IDX_W + 1;

   logic              wait_q;
   logic [IDX_W-1:0]  avail;
   logic [CNT_W-1:0]  free_slots;
   logic [MW-1:0]     cnt_sel;
   logic [CNT_W-1:0]  fcnt;
   logic [ADDR_W-1:0] addr_c;
   logic [IW1-1:0]    ptr_sum;
   logic              fire;

   drc_addr_gen #(.ADDR_W(ADDR_W), .IDX_W(IDX_W), .DESC_BYTES(DESC_BYTES)) u_ag (
      .base (base),
      .idx  (cptr),
      .addr (addr_c)
   );

   always_comb begin
      if (len == '0)
         avail = '0;
      else if (tail >= cptr)
         avail = tail - cptr;
      else
         avail = len - cptr;
      free_slots = CNT_W'(DEPTH) - used - unused;
      cnt_sel    = (MW'(avail) > MW'(free_slots)) ? MW'(free_slots) : MW'(avail);
      fcnt       = CNT_W'(cnt_sel);
      ptr_sum    = IW1'(cptr) + IW1'(req_cnt);
   end

   assign busy    = req_valid | wait_q;
   assign fire    = !busy && !ld && (fcnt != '0);
   assign fill_en = wait_q && done;

   always_ff @(posedge clk) begin
      if (rst) begin
         req_valid <= 1'b0;
         wait_q    <= 1'b0;
         req_addr  <= '0;
         req_cnt   <= '0;
         cptr      <= '0;
      end else begin
         if (fire) begin
            req_valid <= 1'b1;
            req_addr  <= addr_c;
            req_cnt   <= fcnt;
         end else if (req_valid && req_ready) begin
            req_valid <= 1'b0;
            wait_q    <= 1'b1;
         end
         if (fill_en) begin
            wait_q <= 1'b0;
            cptr   <= (ptr_sum == IW1'(len)) ? '0 : IDX_W'(ptr_sum);
         end else if (ld) begin
            cptr <= ld_val;
         end
      end
   end

   p_fetch_no_wrap_r2: assert property (@(posedge clk) disable iff (rst)
      (req_valid && $stable(len)) |-> ((IW1'(cptr) + IW1'(req_cnt)) <= IW1'(len)));

   p_fetch_cap_r3: assert property (@(posedge clk) disable iff (rst)
      req_valid |-> ((32'(used) + 32'(unused) + 32'(req_cnt)) <= 32'(DEPTH)));

   p_fetch_nonzero_r4: assert property (@(posedge clk) disable iff (rst)
      req_valid |-> (req_cnt != '0));

   p_rd_hold_r12: assert property (@(posedge clk) disable iff (rst)
      (req_valid && !req_ready) |=> (req_valid && $stable(req_addr) && $stable(req_cnt)));

endmodule

// File: rtl/drc_writeback.sv
module drc_writeback
   import drc_pkg::*;
#(
   parameter int ADDR_W     = 32,
   parameter int IDX_W      = 12,
   parameter int DESC_BYTES = 16,
   parameter int CNT_W      = 5
) (
   input  logic              clk,
   input  logic              rst,
   input  logic [ADDR_W-1:0] base,
   input  logic [IDX_W-1:0]  len,
   input  logic [CNT_W-1:0]  used,
   input  logic [CNT_W-1:0]  mask,
   input  logic              start,
   input  logic              ld,
   input  logic [IDX_W-1:0]  ld_val,
   output logic              req_valid,
   input  logic              req_ready,
   output logic [ADDR_W-1:0] req_addr,
   output logic [CNT_W-1:0]  req_cnt,
   input  logic              done,
   output logic [IDX_W-1:0]  head,
   output logic              retire_en,
   output logic              busy
);

   localparam int WW  = max2(IDX_W, CNT_W) + 1;
   localparam int IW1 = IDX_W + 1;

   logic              wait_q;
   logic              retry_q;
   logic [WW-1:0]     hsum;
   logic [IDX_W-1:0]  room;
   logic [CNT_W-1:0]  n;
   logic [ADDR_W-1:0] addr_c;
   logic [IW1-1:0]    head_sum;
   logic              try_wb;

   drc_addr_gen #(.ADDR_W(ADDR_W), .IDX_W(IDX_W), .DESC_BYTES(DESC_BYTES)) u_ag (
      .base (base),
      .idx  (head),
      .addr (addr_c)
   );

   always_comb begin
      hsum = WW'(head) + WW'(used);
      room = len - head;
      if (hsum >= WW'(len))
         n = CNT_W'(room);
      else if (mask != '0)
         n = used & ~mask;
      else
         n = used;
      head_sum = IW1'(head) + IW1'(req_cnt);
   end

   assign busy      = req_valid | wait_q;
   assign try_wb    = (start | retry_q) && !busy;
   assign retire_en = wait_q && done;

   always_ff @(posedge clk) begin
      if (rst) begin
         req_valid <= 1'b0;
         wait_q    <= 1'b0;
         retry_q   <= 1'b0;
         req_addr  <= '0;
         req_cnt   <= '0;
         head      <= '0;
      end else begin
         if (try_wb) begin
            retry_q <= 1'b0;
            if (n != '0) begin
               req_valid <= 1'b1;
               req_addr  <= addr_c;
               req_cnt   <= n;
            end
         end else if (req_valid && req_ready) begin
            req_valid <= 1'b0;
            wait_q    <= 1'b1;
         end
         if (retire_en) begin
            wait_q  <= 1'b0;
            retry_q <= (used != req_cnt);
            head    <= (head_sum >= IW1'(len)) ? IDX_W'(head_sum - IW1'(len))
                                               : IDX_W'(head_sum);
         end else if (ld) begin
            head <= ld_val;
         end
      end
   end

   p_wb_no_wrap_r7: assert property (@(posedge clk) disable iff (rst)
      (req_valid && $stable(len)) |-> ((IW1'(head) + IW1'(req_cnt)) <= IW1'(len)));

   p_wb_nonzero_r8: assert property (@(posedge clk) disable iff (rst)
      req_valid |-> (req_cnt != '0));

   p_wr_hold_r12: assert property (@(posedge clk) disable iff (rst)
      (req_valid && !req_ready) |=> (req_valid && $stable(req_addr) && $stable(req_cnt)));

endmodule

// File: rtl/drc_occupancy.sv
module drc_occupancy #(
   parameter int DEPTH = 16,
   parameter int CNT_W = 5
) (
   input  logic             clk,
   input  logic             rst,
   input  logic             fill_en,
   input  logic [CNT_W-1:0] fill_cnt,
   input  logic             retire_en,
   input  logic [CNT_W-1:0] retire_cnt,
   input  logic             consume,
   output logic [CNT_W-1:0] unused,
   output logic [CNT_W-1:0] used
);

   logic take;

   assign take = consume && (unused != '0);

   always_ff @(posedge clk) begin
      if (rst) begin
         unused <= '0;
         used   <= '0;
      end else begin
         unused <= unused + (fill_en ? fill_cnt : '0) - CNT_W'(take);
         used   <= used + CNT_W'(take) - (retire_en ? retire_cnt : '0);
      end
   end

   p_occ_bound_r3: assert property (@(posedge clk) disable iff (rst)
      (32'(used) + 32'(unused)) <= 32'(DEPTH));

   p_retire_le_used_r9: assert property (@(posedge clk) disable iff (rst)
      retire_en |-> (retire_cnt <= used));

   p_consume_empty_r6: assert property (@(posedge clk) disable iff (rst)
      (consume && unused == '0 && !fill_en) |=> (unused == '0));

endmodule

// File: rtl/desc_ring_cache.sv
module desc_ring_cache #(
   parameter int ADDR_W     = 32,
   parameter int IDX_W      = 12,
   parameter int DEPTH      = 16,
   parameter int DESC_BYTES = 16,
   parameter int CNT_W      = $clog2(DEPTH + 1)
) (
   input  logic              clk,
   input  logic              rst,
   input  logic [ADDR_W-1:0] ring_base,
   input  logic [IDX_W-1:0]  ring_len,
   input  logic [IDX_W-1:0]  ring_tail,
   input  logic              head_wr,
   input  logic [IDX_W-1:0]  head_wr_val,
   input  logic [CNT_W-1:0]  wb_align,
   input  logic              wb_start,
   input  logic              consume,
   output logic              rd_valid,
   input  logic              rd_ready,
   output logic [ADDR_W-1:0] rd_addr,
   output logic [CNT_W-1:0]  rd_cnt,
   input  logic              rd_done,
   output logic              wr_valid,
   input  logic              wr_ready,
   output logic [ADDR_W-1:0] wr_addr,
   output logic [CNT_W-1:0]  wr_cnt,
   input  logic              wr_done,
   output logic [IDX_W-1:0]  ring_head,
   output logic [IDX_W-1:0]  cache_ptr,
   output logic [CNT_W-1:0]  unused_cnt,
   output logic [CNT_W-1:0]  used_cnt,
   output logic              cfg_err
);

   initial begin
      a_depth_ok: assert (DEPTH >= 1 && CNT_W >= $clog2(DEPTH + 1))
         else $error("cache depth or count width out of range");
      a_idx_ok: assert (IDX_W >= 1 && ADDR_W >= IDX_W)
         else $error("index or address width out of range");
      a_desc_ok: assert (DESC_BYTES >= 1)
         else $error("descriptor size must be positive");
   end

   logic              fill_en, retire_en;
   logic              f_busy, w_busy;
   logic [ADDR_W-1:0] base_q;
   logic [IDX_W-1:0]  len_q;
   logic              geo_change, active;

   drc_occupancy #(.DEPTH(DEPTH), .CNT_W(CNT_W)) u_occ (
      .clk        (clk),
      .rst        (rst),
      .fill_en    (fill_en),
      .fill_cnt   (rd_cnt),
      .retire_en  (retire_en),
      .retire_cnt (wr_cnt),
      .consume    (consume),
      .unused     (unused_cnt),
      .used       (used_cnt)
   );

   drc_fetch #(.ADDR_W(ADDR_W), .IDX_W(IDX_W), .DEPTH(DEPTH),
               .DESC_BYTES(DESC_BYTES), .CNT_W(CNT_W)) u_fetch (
      .clk       (clk),
      .rst       (rst),
      .base      (ring_base),
      .len       (ring_len),
      .tail      (ring_tail),
      .used      (used_cnt),
      .unused    (unused_cnt),
      .ld        (head_wr),
      .ld_val    (head_wr_val),
      .req_valid (rd_valid),
      .req_ready (rd_ready),
      .req_addr  (rd_addr),
      .req_cnt   (rd_cnt),
      .done      (rd_done),
      .cptr      (cache_ptr),
      .fill_en   (fill_en),
      .busy      (f_busy)
   );

   drc_writeback #(.ADDR_W(ADDR_W), .IDX_W(IDX_W),
                   .DESC_BYTES(DESC_BYTES), .CNT_W(CNT_W)) u_wb (
      .clk       (clk),
      .rst       (rst),
      .base      (ring_base),
      .len       (ring_len),
      .used      (used_cnt),
      .mask      (wb_align),
      .start     (wb_start),
      .ld        (head_wr),
      .ld_val    (head_wr_val),
      .req_valid (wr_valid),
      .req_ready (wr_ready),
      .req_addr  (wr_addr),
      .req_cnt   (wr_cnt),
      .done      (wr_done),
      .head      (ring_head),
      .retire_en (retire_en),
      .busy      (w_busy)
   );

   assign geo_change = (ring_base != base_q) || (ring_len != len_q) || head_wr;
   assign active     = (unused_cnt != '0) || (used_cnt != '0) || f_busy || w_busy;

   always_ff @(posedge clk) begin
      base_q <= ring_base;
      len_q  <= ring_len;
      if (rst)
         cfg_err <= 1'b0;
      else if (geo_change && active)
         cfg_err <= 1'b1;
   end

   p_err_sticky_r11: assert property (@(posedge clk) disable iff (rst)
      cfg_err |=> cfg_err);

   p_head_load_r10: assert property (@(posedge clk) disable iff (rst)
      (head_wr && !w_busy) |=> (ring_head == $past(head_wr_val)));

endmodule

// File: tb/tb_desc_ring_cache.sv
`timescale 1ns/1ps
module tb_desc_ring_cache;

   localparam int ADDR_W = 16;
   localparam int IDX_W  = 4;
   localparam int DEPTH  = 4;
   localparam int DBYTES = 16;
   localparam int CNT_W  = 3;
   localparam int BASE   = 'h1000;

   logic              clk = 1'b0;
   logic              rst;
   logic [ADDR_W-1:0] ring_base;
   logic [IDX_W-1:0]  ring_len, ring_tail, head_wr_val;
   logic              head_wr, wb_start, consume;
   logic [CNT_W-1:0]  wb_align;
   logic              rd_valid, rd_ready, rd_done;
   logic [ADDR_W-1:0] rd_addr, wr_addr;
   logic [CNT_W-1:0]  rd_cnt, wr_cnt;
   logic              wr_valid, wr_ready, wr_done;
   logic [IDX_W-1:0]  ring_head, cache_ptr;
   logic [CNT_W-1:0]  unused_cnt, used_cnt;
   logic              cfg_err;

   int  n_tests = 0;
   int  n_fail  = 0;
   bit  finished = 1'b0;

   always #4 clk = ~clk;

   desc_ring_cache #(.ADDR_W(ADDR_W), .IDX_W(IDX_W), .DEPTH(DEPTH),
                     .DESC_BYTES(DBYTES), .CNT_W(CNT_W)) dut (
      .clk(clk), .rst(rst), .ring_base(ring_base), .ring_len(ring_len),
      .ring_tail(ring_tail), .head_wr(head_wr), .head_wr_val(head_wr_val),
      .wb_align(wb_align), .wb_start(wb_start), .consume(consume),
      .rd_valid(rd_valid), .rd_ready(rd_ready), .rd_addr(rd_addr), .rd_cnt(rd_cnt),
      .rd_done(rd_done), .wr_valid(wr_valid), .wr_ready(wr_ready), .wr_addr(wr_addr),
      .wr_cnt(wr_cnt), .wr_done(wr_done), .ring_head(ring_head), .cache_ptr(cache_ptr),
      .unused_cnt(unused_cnt), .used_cnt(used_cnt), .cfg_err(cfg_err)
   );

   // fetch table: ring length, loaded head, tail, expected read count
   localparam int NV = 5;
   localparam int V_LEN [NV] = '{10, 10, 10, 10, 0};
   localparam int V_HEAD[NV] = '{ 2,  2,  8,  6, 2};
   localparam int V_TAIL[NV] = '{ 5,  9,  3,  6, 5};
   localparam int V_CNT [NV] = '{ 3,  4,  2,  0, 0};

   task automatic tick();
      @(posedge clk);
      #1;
   endtask

   task automatic chk(input string req, input int act, input int exp);
      n_tests++;
      if (act != exp) begin
         n_fail++;
         $display("FAIL %s: actual %0d expected %0d", req, act, exp);
      end
   endtask

   task automatic do_reset();
      rst = 1'b1; ring_base = ADDR_W'(BASE); ring_len = '0; ring_tail = '0;
      head_wr = 1'b0; head_wr_val = '0; wb_align = '0; wb_start = 1'b0;
      consume = 1'b0; rd_ready = 1'b0; rd_done = 1'b0; wr_ready = 1'b0; wr_done = 1'b0;
      repeat (3) tick();
      rst = 1'b0;
      tick();
   endtask

   task automatic load_head(input int h);
      head_wr = 1'b1; head_wr_val = IDX_W'(h);
      tick();
      head_wr = 1'b0;
   endtask

   task automatic wait_rd(input string req, input int ecnt, input int eaddr);
      for (int k = 0; k < 10 && !rd_valid; k++) tick();
      chk(req, int'(rd_valid), 1);
      chk(req, int'(rd_cnt), ecnt);
      chk(req, int'(rd_addr), eaddr);
   endtask

   task automatic wait_wr(input string req, input int ecnt, input int eaddr);
      for (int k = 0; k < 10 && !wr_valid; k++) tick();
      chk(req, int'(wr_valid), 1);
      chk(req, int'(wr_cnt), ecnt);
      chk(req, int'(wr_addr), eaddr);
   endtask

   task automatic finish_rd();
      rd_ready = 1'b1; tick(); rd_ready = 1'b0;
      rd_done = 1'b1; tick(); rd_done = 1'b0;
   endtask

   task automatic finish_wr();
      wr_ready = 1'b1; tick(); wr_ready = 1'b0;
      wr_done = 1'b1; tick(); wr_done = 1'b0;
   endtask

   task automatic no_rd(input string req);
      int seen = 0;
      for (int k = 0; k < 6; k++) begin tick(); if (rd_valid) seen = 1; end
      chk(req, seen, 0);
   endtask

   task automatic no_wr(input string req);
      int seen = 0;
      for (int k = 0; k < 6; k++) begin tick(); if (wr_valid) seen = 1; end
      chk(req, seen, 0);
   endtask

   initial begin
      repeat (60000) @(posedge clk);
      if (!finished) begin
         n_tests++; n_fail++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
         $finish;
      end
   end

   initial begin
      // R1 reset state
      do_reset();
      chk("R1 unused", int'(unused_cnt), 0);
      chk("R1 used", int'(used_cnt), 0);
      chk("R1 head", int'(ring_head), 0);
      chk("R1 cptr", int'(cache_ptr), 0);
      chk("R1 err", int'(cfg_err), 0);
      chk("R1 rd", int'(rd_valid), 0);
      chk("R1 wr", int'(wr_valid), 0);

      // table walk: R2 R3 R4 R10 R12
      for (int i = 0; i < NV; i++) begin
         do_reset();
         load_head(V_HEAD[i]);
         chk("R10 head", int'(ring_head), V_HEAD[i]);
         chk("R10 cptr", int'(cache_ptr), V_HEAD[i]);
         chk("R11 idle load", int'(cfg_err), 0);
         ring_len = IDX_W'(V_LEN[i]); ring_tail = IDX_W'(V_TAIL[i]);
         if (V_CNT[i] > 0) begin
            wait_rd("R2 R3 R4 fetch", V_CNT[i], BASE + V_HEAD[i] * DBYTES);
            repeat (3) tick();
            chk("R12 rd held", int'(rd_valid), 1);
            chk("R12 rd cnt", int'(rd_cnt), V_CNT[i]);
            chk("R12 rd addr", int'(rd_addr), BASE + V_HEAD[i] * DBYTES);
         end else begin
            no_rd("R2 R4 zero count");
         end
      end

      // directed: pointer wrap, free-slot cap, consume, writeback wrap and retry
      do_reset();
      load_head(8);
      ring_len = 4'd10; ring_tail = 4'd3;
      wait_rd("R2 to ring end", 2, BASE + 8 * DBYTES);
      finish_rd();
      chk("R5 cptr wraps", int'(cache_ptr), 0);
      chk("R5 unused", int'(unused_cnt), 2);
      wait_rd("R3 capped", 2, BASE);
      finish_rd();
      chk("R5 cptr", int'(cache_ptr), 2);
      chk("R5 unused full", int'(unused_cnt), 4);
      no_rd("R3 no free slot");
      ring_tail = 4'd2;
      consume = 1'b1;
      repeat (4) tick();
      chk("R6 used", int'(used_cnt), 4);
      chk("R6 unused", int'(unused_cnt), 0);
      tick();
      consume = 1'b0;
      chk("R6 empty consume used", int'(used_cnt), 4);
      chk("R6 empty consume unused", int'(unused_cnt), 0);
      wb_start = 1'b1; tick(); wb_start = 1'b0;
      wait_wr("R7 cut at ring end", 2, BASE + 8 * DBYTES);
      finish_wr();
      chk("R9 head wraps", int'(ring_head), 0);
      chk("R9 used", int'(used_cnt), 2);
      wait_wr("R9 retry", 2, BASE);
      finish_wr();
      chk("R9 head", int'(ring_head), 2);
      chk("R9 used drained", int'(used_cnt), 0);
      no_wr("R9 no retry when empty");

      // directed: alignment mask and error on busy head load
      do_reset();
      load_head(0);
      ring_len = 4'd12; ring_tail = 4'd3;
      wait_rd("R4 fetch", 3, BASE);
      finish_rd();
      consume = 1'b1; repeat (3) tick(); consume = 1'b0;
      chk("R6 used three", int'(used_cnt), 3);
      wb_align = 3'd1;
      wb_start = 1'b1; tick(); wb_start = 1'b0;
      wait_wr("R8 aligned", 2, BASE);
      finish_wr();
      chk("R9 head", int'(ring_head), 2);
      chk("R9 used left", int'(used_cnt), 1);
      no_wr("R8 aligned zero");
      chk("R8 used kept", int'(used_cnt), 1);
      chk("R11 before", int'(cfg_err), 0);
      load_head(5);
      chk("R11 head load nonempty", int'(cfg_err), 1);
      repeat (2) tick();
      chk("R11 sticky", int'(cfg_err), 1);
      do_reset();
      chk("R1 err cleared", int'(cfg_err), 0);

      // directed: base change during outstanding fetch
      ring_len = 4'd10; ring_tail = 4'd4;
      wait_rd("R4 fetch", 4, BASE);
      ring_base = ADDR_W'('h2000);
      tick();
      chk("R11 base change busy", int'(cfg_err), 1);

      finished = 1'b1;
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   end

endmodule